// File: doc/BRIEF.md
# Self-Clearing Command Trigger Register File

This block is a small paged register file that lets a host start timed internal operations. The host sends 16-bit frames. A write frame carries a write flag, a 7-bit register address and one data byte. A read frame carries only an address, and the addressed 16-bit word comes back one cycle later. A page register, reachable at address 0x00 on every page, selects which bank of registers the other addresses refer to.

Page 3 holds a command register. Writing 1 to one of its defined bits starts an operation. That bit reads back as 1 while the operation runs and returns to 0 by itself when the operation ends. Each operation is a stub: a busy interval whose length is a fixed number of milliseconds, counted in ticks of the clock. Starting a factory-restore, flash-update or bias-null operation adds one to a 32-bit flash-update count. Page 2 holds that count as two words. When a software reset finishes, the page register returns to its default, and a one-cycle pulse tells the rest of the chip to restart data collection.

Top module: `cmd_trigger_regs`

## Requirements
- R1: A frame with bit 15 = 1 is a write: bits 14:8 give the address and bits 7:0 give the data byte. A frame with bit 15 = 0 is a read of the word at bits 14:8, with address bit 0 ignored. The word appears on `rd_data`, with `rd_valid` high, in the cycle after the read frame.
- R2: The page register sits at address 0x00 on every page and takes the written byte. It resets to 0 and reads back in bits 7:0.
- R3: The command register sits on page 3 at address 0x02, and its low byte is written there. Bit 7 is software reset, bit 6 factory restore, bit 3 flash update, bit 2 flash test, bit 1 self-test and bit 0 bias null. Writing 1 to a defined bit starts that operation, and the bit reads 1 while the operation runs. If several defined bits are written together, only the highest-numbered one starts.
- R4: Bits 15:8 and 5:4 are unused and read 0. Writing only those bits, or writing address 0x03, starts nothing.
- R5: Each operation runs for its own time: bit 7 120 ms, bit 6 75 ms, bit 3 375 ms, bit 2 50 ms, bit 1 12 ms, and bit 0 BIAS_MS ms. One millisecond is TICKS_PER_MS cycles. `busy` stays high for exactly ms × TICKS_PER_MS cycles, counted from the edge that accepts the write. Then the bit clears by itself.
- R6: A command write while an operation runs is ignored: the register content does not change and the flash count does not change.
- R7: The 32-bit flash-update count starts at 0 and rises by 1 each time a bit 6, bit 3 or bit 0 operation starts. Its low word is read on page 2 at address 0x7C and its high word on page 2 at address 0x7E.
- R8: When a software reset completes, the page register returns to 0. `restart_pulse` is high for exactly one cycle, the cycle after `busy` falls. The flash count keeps its value.
- R9: The command register cannot be reached from any page other than 3. A write to address 0x02 on page 0 starts nothing, and a read of any unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Frame on `frame` is present this cycle |
| frame | input | 16 | Host frame (write flag, address, data) |
| rd_data | output | 16 | Word returned for the previous read frame |
| rd_valid | output | 1 | `rd_data` holds a read result |
| busy | output | 1 | A command operation is running |
| restart_pulse | output | 1 | One-cycle request to restart data collection after software reset |

## Verification
A write is accepted on the rising edge where its frame is present. From that edge on, `busy` and the command bit are already visible at the following falling edge. The bench therefore counts `busy` samples at falling edges, starting with the sample right after the write, and expects exactly ms × TICKS_PER_MS of them. A read result is registered once, so the bench presents the read frame at a falling edge and samples `rd_data` at the next falling edge. `restart_pulse` is registered from the completion event, so the bench expects it at the first falling edge where `busy` reads 0 and expects it gone one edge later. Flash-count effects are checked by reading both words on page 2 after each operation ends.

// File: rtl/cmdtrig_pkg.sv
package cmdtrig_pkg;
  localparam int ADDR_W = 7;
  localparam int NV_W   = 32;

  localparam logic [ADDR_W-1:0] PAGE_ADDR   = 7'h00;
  localparam logic [ADDR_W-1:0] CMD_ADDR    = 7'h02;
  localparam logic [ADDR_W-1:0] NV_LO_ADDR  = 7'h7C;
  localparam logic [ADDR_W-1:0] NV_HI_ADDR  = 7'h7E;
  localparam logic [7:0]        CMD_PAGE    = 8'd3;
  localparam logic [7:0]        NV_PAGE     = 8'd2;
  localparam logic [7:0]        DEF_MASK    = 8'hCF;
  localparam logic [2:0]        SWRST_IDX   = 3'd7;

  // Operation length in milliseconds, by command bit index.
  function automatic int unsigned op_ms(input logic [2:0] idx, input int unsigned bias_ms);
    case (idx)
      3'd7:    return 120;
      3'd6:    return 75;
      3'd3:    return 375;
      3'd2:    return 50;
      3'd1:    return 12;
      3'd0:    return bias_ms;
      default: return 0;
    endcase
  endfunction

  // {valid, index} of the highest defined bit set in a written byte.
  function automatic logic [3:0] pick_op(input logic [7:0] req);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 0; i < 8; i++) begin
      if (req[i] && DEF_MASK[i]) r = {1'b1, 3'(i)};
    end
    return r;
  endfunction

  // Operations that rewrite nonvolatile storage.
  function automatic logic writes_flash(input logic [2:0] idx);
    return (idx == 3'd6) || (idx == 3'd3) || (idx == 3'd0);
  endfunction
endpackage

// File: rtl/cmdtrig_frame_dec.sv
module cmdtrig_frame_dec
  import cmdtrig_pkg::*;
(
  input  logic              frame_valid,
  input  logic [15:0]       frame,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);
  assign wr_stb = frame_valid &&  frame[15];
  assign rd_stb = frame_valid && !frame[15];
  assign addr   = frame[14:8];
  assign data   = frame[7:0];
endmodule

// File: rtl/cmdtrig_seq.sv
module cmdtrig_seq
  import cmdtrig_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned BIAS_MS      = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [7:0]  wr_data,
  output logic [15:0] cmd_bits,
  output logic        busy,
  output logic        start_evt,
  output logic [2:0]  start_idx,
  output logic        done_evt,
  output logic [2:0]  done_idx
);
  localparam int unsigned MAX_MS    = (BIAS_MS > 375) ? BIAS_MS : 375;
  localparam int unsigned MAX_TICKS = MAX_MS * TICKS_PER_MS;
  localparam int          CNT_W     = $clog2(MAX_TICKS + 1);

  logic             run_q;
  logic [2:0]       idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       pick;
  logic [31:0]      load_ticks;

  assign pick       = pick_op(wr_data);
  assign start_evt  = cmd_wr && !run_q && pick[3];
  assign start_idx  = pick[2:0];
  assign load_ticks = op_ms(pick[2:0], BIAS_MS) * TICKS_PER_MS;
  assign done_evt   = run_q && (cnt_q == CNT_W'(1));
  assign done_idx   = idx_q;
  assign busy       = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      idx_q <= 3'd0;
      cnt_q <= '0;
    end else if (start_evt) begin
      run_q <= 1'b1;
      idx_q <= pick[2:0];
      cnt_q <= load_ticks[CNT_W-1:0];
    end else if (done_evt) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  for (genvar g = 0; g < 16; g++) begin : g_bit
    if (g < 8 && DEF_MASK[g % 8]) begin : g_def
      assign cmd_bits[g] = run_q && (idx_q == 3'(g));
    end else begin : g_unused
      assign cmd_bits[g] = 1'b0;
    end
  end
endmodule

// File: rtl/cmdtrig_nvcount.sv
module cmdtrig_nvcount
  import cmdtrig_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  output logic [NV_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + NV_W'(1);
  end
endmodule

// File: rtl/cmd_trigger_regs.sv
module cmd_trigger_regs
  import cmdtrig_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned BIAS_MS      = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_valid,
  input  logic [15:0] frame,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  output logic        busy,
  output logic        restart_pulse
);
  logic              wr_stb, rd_stb;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        data;
  logic [7:0]        page_q;
  logic              cmd_wr, page_wr;
  logic [15:0]       cmd_bits;
  logic              start_evt, done_evt;
  logic [2:0]        start_idx, done_idx;
  logic              flash_inc, swrst_done;
  logic [NV_W-1:0]   flash_cnt;
  logic [ADDR_W-1:0] rd_addr;
  logic [15:0]       rd_word;
  logic              restart_q;

  cmdtrig_frame_dec u_dec (
    .frame_valid(frame_valid), .frame(frame),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr), .data(data)
  );

  assign page_wr = wr_stb && (addr == PAGE_ADDR);
  assign cmd_wr  = wr_stb && (page_q == CMD_PAGE) && (addr == CMD_ADDR);

  cmdtrig_seq #(.TICKS_PER_MS(TICKS_PER_MS), .BIAS_MS(BIAS_MS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wr_data(data),
    .cmd_bits(cmd_bits), .busy(busy),
    .start_evt(start_evt), .start_idx(start_idx),
    .done_evt(done_evt), .done_idx(done_idx)
  );

  assign flash_inc  = start_evt && writes_flash(start_idx);
  assign swrst_done = done_evt && (done_idx == SWRST_IDX);

  cmdtrig_nvcount u_nv (
    .clk(clk), .rst_n(rst_n), .inc(flash_inc), .count(flash_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q    <= 8'd0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= swrst_done;
      if (swrst_done)   page_q <= 8'd0;
      else if (page_wr) page_q <= data;
    end
  end
  assign restart_pulse = restart_q;

  assign rd_addr = {addr[ADDR_W-1:1], 1'b0};
  always_comb begin
    rd_word = 16'h0000;
    if (rd_addr == PAGE_ADDR)
      rd_word = {8'h00, page_q};
    else if (page_q == CMD_PAGE && rd_addr == CMD_ADDR)
      rd_word = cmd_bits;
    else if (page_q == NV_PAGE && rd_addr == NV_LO_ADDR)
      rd_word = flash_cnt[15:0];
    else if (page_q == NV_PAGE && rd_addr == NV_HI_ADDR)
      rd_word = flash_cnt[31:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= 16'h0000;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= rd_word;
    end
  end
endmodule

// File: rtl/cmdtrig_chk.sv
module cmdtrig_chk
  import cmdtrig_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_wr,
  input logic            busy,
  input logic [15:0]     cmd_bits,
  input logic            start_evt,
  input logic [2:0]      start_idx,
  input logic            done_evt,
  input logic [NV_W-1:0] flash_cnt,
  input logic            restart_pulse,
  input logic [7:0]      page,
  input logic            rd_stb,
  input logic            rd_valid
);
  // R1
  rd_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  // R3
  onehot_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_bits));
  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cmd_bits == (16'h0001 << $past(start_idx))));
  // R5
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_evt));
  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && !done_evt) |=> $stable(cmd_bits));
  // R7
  nv_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && writes_flash(start_idx)) |=> (flash_cnt == $past(flash_cnt) + NV_W'(1)));
  // R7
  nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(flash_cnt));
  // R8
  restart_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> (page == 8'd0));
  // R8
  restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> !restart_pulse);
endmodule

bind cmd_trigger_regs cmdtrig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .busy(busy), .cmd_bits(cmd_bits),
  .start_evt(start_evt), .start_idx(start_idx), .done_evt(done_evt),
  .flash_cnt(flash_cnt), .restart_pulse(restart_pulse), .page(page_q),
  .rd_stb(rd_stb), .rd_valid(rd_valid)
);

// File: tb/cmd_trigger_regs_tb.sv
module cmd_trigger_regs_tb;
  localparam int TPM  = 2;
  localparam int BIAS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic [15:0] frame = 16'h0000;
  logic [15:0] rd_data;
  logic        rd_valid, busy, restart_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  cmd_trigger_regs #(.TICKS_PER_MS(TPM), .BIAS_MS(BIAS)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame(frame),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .restart_pulse(restart_pulse)
  );

  always #4 clk = ~clk;

  // {data byte, bit index, writes flash, duration in ms}
  localparam logic [31:0] VEC [8] = '{
    {8'h02, 4'd1, 4'd0, 16'd12},
    {8'h04, 4'd2, 4'd0, 16'd50},
    {8'h08, 4'd3, 4'd1, 16'd375},
    {8'h40, 4'd6, 4'd1, 16'd75},
    {8'h01, 4'd0, 4'd1, 16'(BIAS)},
    {8'h03, 4'd1, 4'd0, 16'd12},
    {8'h4A, 4'd6, 4'd1, 16'd75},
    {8'h80, 4'd7, 4'd0, 16'd120}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    frame_valid = 1'b1;
    frame = {1'b1, a, d};
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] v);
    @(negedge clk);
    frame_valid = 1'b1;
    frame = {1'b0, a, 8'h00};
    @(negedge clk);
    frame_valid = 1'b0;
    check("R1 rd_valid", 32'(rd_valid), 32'd1);
    v = rd_data;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int exp_cnt;
    exp_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    check("R5 busy after reset", 32'(busy), 32'd0);
    rd(7'h00, v); check("R2 page reset", 32'(v), 32'd0);
    rd(7'h02, v); check("R9 unmapped read page 0", 32'(v), 32'd0);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      int idx, ms, fl, cnt, rpulse;
      d   = VEC[i][31:24];
      idx = int'(VEC[i][23:20]);
      fl  = int'(VEC[i][19:16]);
      ms  = int'(VEC[i][15:0]);
      wr(7'h00, 8'd3);
      wr(7'h02, d);
      cnt = busy ? 1 : 0;
      frame_valid = 1'b1;
      frame = {1'b0, 7'h02, 8'h00};
      @(negedge clk);
      frame_valid = 1'b0;
      if (busy) cnt++;
      check("R3 cmd bit reads 1", 32'(rd_data), 32'(16'h0001 << idx));
      for (int k = 0; k < 2000 && busy; k++) begin
        @(negedge clk);
        if (busy) cnt++;
      end
      rpulse = restart_pulse;
      check("R5 busy duration", 32'(cnt), 32'(ms * TPM));
      if (idx == 7) begin
        check("R8 restart pulse", 32'(rpulse), 32'd1);
        @(negedge clk);
        check("R8 restart one cycle", 32'(restart_pulse), 32'd0);
        rd(7'h00, v); check("R8 page back to 0", 32'(v), 32'd0);
      end else begin
        rd(7'h02, v); check("R5 bit self-cleared", 32'(v), 32'd0);
      end
      exp_cnt += fl;
      wr(7'h00, 8'd2);
      rd(7'h7C, v); check("R7 count low word", 32'(v), 32'(exp_cnt));
    end

    // R8: count kept through software reset; high word
    rd(7'h7E, v); check("R7 count high word", 32'(v), 32'd0);
    rd(7'h7D, v); check("R1 odd address bit ignored", 32'(v), 32'(exp_cnt));

    // R6: writes while busy are ignored
    wr(7'h00, 8'd3);
    wr(7'h02, 8'h02);
    wr(7'h02, 8'h40);
    rd(7'h02, v); check("R6 busy write ignored", 32'(v), 32'h0002);
    wait_idle();
    wr(7'h00, 8'd2);
    rd(7'h7C, v); check("R6 count unchanged", 32'(v), 32'(exp_cnt));

    // R4: unused bits and upper byte
    wr(7'h00, 8'd3);
    wr(7'h02, 8'h30);
    @(negedge clk); check("R4 bits 5:4 start nothing", 32'(busy), 32'd0);
    wr(7'h03, 8'hFF);
    @(negedge clk); check("R4 upper byte starts nothing", 32'(busy), 32'd0);

    // R9: command address on another page
    wr(7'h00, 8'd0);
    wr(7'h02, 8'h02);
    @(negedge clk); check("R9 page 0 write starts nothing", 32'(busy), 32'd0);
    rd(7'h00, v); check("R2 page readback", 32'(v), 32'd0);
    wr(7'h00, 8'h5A);
    rd(7'h00, v); check("R2 page holds byte", 32'(v), 32'h5A);
    rd(7'h40, v); check("R9 unmapped read", 32'(v), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule